// File: doc/BRIEF.md
# Supervisory Mode Controller with Keep-Alive Watchdog

This block decides which of four operating modes a programmable-logic control core is in. A processor asks for the next mode over a two-bit request input and proves it is alive by toggling a keep-alive line. The controller holds the current mode and reports it. It also drives a one-hot enable vector, one bit per mode, and routes the output of the matching per-mode datapath onto a shared output bus. Every per-mode datapath receives the shared input bus at the same time. A status LED gives each mode its own light pattern.

Two conditions force the safe mode. The first is a keep-alive watchdog that expires when the line stops toggling. The second is an external alarm level. Once in the safe mode the controller stays there. It returns to the initial mode only when the alarm is low, the watchdog flag is low, and the processor explicitly asks for the initial mode. A test input can mask the watchdog flag. In this block the per-mode datapaths are plain stand-in registers: lane k registers the input bus plus k.

Top module: `mode_supervisor`

## Requirements
- R1: After a synchronous reset the mode is initial (code 0), the enable vector is 0001, the LED is off and the watchdog flag is low.
- R2: Mode codes are initial=0, stop=1, run=2, safe=3. While the mode is not safe and neither the alarm nor the visible watchdog flag is set, the mode one cycle later equals the requested code.
- R3: A high alarm forces the safe mode (3) on the next clock edge, whatever the current mode and request.
- R4: If the keep-alive input does not change level for more than WDT_CYCLES clock edges, the watchdog flag rises and the mode goes to safe on the following edge.
- R5: Once raised, the watchdog flag stays high until the keep-alive input changes level. Each change of level restarts the full timeout window.
- R6: In the safe mode, a request for stop or run is ignored. A request for initial is also ignored while the alarm or the visible watchdog flag is high. A keep-alive that resumes does not by itself leave the safe mode.
- R7: In the safe mode, with the alarm and the visible watchdog flag both low, a request for initial (0) moves the mode to initial on the next edge.
- R8: While the mask input is high, the watchdog flag output reads 0 and cannot force the safe mode.
- R9: The LED is off in initial and steadily on in stop. In run and safe it is on for the first half-period after entering the mode and then toggles every half-period: RUN_HALF cycles in run, SAFE_HALF cycles in safe.
- R10: The enable vector has exactly bit <mode> set. The shared output equals the lane of the current mode, where lane k holds the previous cycle's input bus plus k, modulo 2^DATA_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_mode | input | 2 | Requested next mode code |
| keepalive | input | 1 | Keep-alive line; any change of level counts as a heartbeat |
| wdt_mask | input | 1 | Test mask for the watchdog flag |
| alarm | input | 1 | External monitoring alarm, active high |
| lane_in | input | DATA_W | Shared input bus, fed to every per-mode lane |
| mode | output | 2 | Current mode code |
| mode_en | output | 4 | One-hot enable, bit k set in mode k |
| lane_out | output | DATA_W | Output of the lane selected by the current mode |
| led | output | 1 | Status LED pattern |
| wdt_flag | output | 1 | Watchdog overrun flag, masked by wdt_mask |

## Verification
The hardest case to reach is the safe-mode lock under a watchdog trip that has since cleared. To get there, the keep-alive toggling must stop for a full window. A safe-mode request for initial must then be refused while the flag is still high. Next the toggling resumes, and the controller must still hold the safe mode under a run request until an explicit request for initial arrives. The bench also masks the watchdog while running and then lifts the mask with the flag already set internally. This shows that the hidden expiry forces the safe mode one edge after the mask drops.

// File: rtl/mode_pkg.sv
package mode_pkg;
  typedef enum logic [1:0] {
    MD_INIT = 2'd0,
    MD_STOP = 2'd1,
    MD_RUN  = 2'd2,
    MD_SAFE = 2'd3
  } mode_t;

  function automatic logic [3:0] mode_onehot(mode_t m);
    return 4'b0001 << m;
  endfunction

  // next mode: a trip wins; the safe mode only opens towards initial
  function automatic mode_t mode_next(mode_t cur, mode_t req, logic trip);
    if (trip)                return MD_SAFE;
    else if (cur == MD_SAFE) return (req == MD_INIT) ? MD_INIT : MD_SAFE;
    else                     return req;
  endfunction
endpackage

// File: rtl/mode_wdog.sv
module mode_wdog #(
  parameter int TIMEOUT = 100_000
) (
  input  logic clk,
  input  logic rst,
  input  logic ka_in,
  input  logic mask,
  output logic ka_edge,
  output logic expired,
  output logic flag
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] RELOAD = CW'(TIMEOUT);

  logic          ka_q;
  logic [CW-1:0] cnt;

  assign ka_edge = ka_in ^ ka_q;
  assign flag    = expired & ~mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      ka_q    <= ka_in;
      cnt     <= RELOAD;
      expired <= 1'b0;
    end else begin
      ka_q <= ka_in;
      if (ka_edge) begin
        cnt     <= RELOAD;
        expired <= 1'b0;
      end else if (cnt == '0) begin
        expired <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
  import mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_t req,
  input  logic  trip,
  output mode_t cur,
  output mode_t nxt
);
  assign nxt = mode_next(cur, req, trip);

  always_ff @(posedge clk) begin
    if (rst) cur <= MD_INIT;
    else     cur <= nxt;
  end
endmodule

// File: rtl/mode_led.sv
module mode_led
  import mode_pkg::*;
#(
  parameter int RUN_HALF  = 50_000_000,
  parameter int SAFE_HALF = 10_000_000
) (
  input  logic  clk,
  input  logic  rst,
  input  mode_t cur,
  input  mode_t nxt,
  output logic  led
);
  localparam int MAXH = (RUN_HALF > SAFE_HALF) ? RUN_HALF : SAFE_HALF;
  localparam int CW   = $clog2(MAXH + 1);

  logic [CW-1:0] cnt;
  logic          blink;
  logic [CW-1:0] last;

  assign last = (cur == MD_RUN) ? CW'(RUN_HALF - 1) : CW'(SAFE_HALF - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      blink <= 1'b0;
    end else if (nxt != cur) begin
      cnt   <= '0;
      blink <= 1'b1;
    end else if (cnt >= last) begin
      cnt   <= '0;
      blink <= ~blink;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    case (cur)
      MD_INIT: led = 1'b0;
      MD_STOP: led = 1'b1;
      default: led = blink;
    endcase
  end
endmodule

// File: rtl/mode_lane.sv
module mode_lane #(
  parameter int DATA_W = 16,
  parameter int IDX    = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d + DATA_W'(IDX);
  end
endmodule

// File: rtl/mode_supervisor.sv
module mode_supervisor
  import mode_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int WDT_CYCLES = 100_000,
  parameter int RUN_HALF  = 50_000_000,
  parameter int SAFE_HALF = 10_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        req_mode,
  input  logic              keepalive,
  input  logic              wdt_mask,
  input  logic              alarm,
  input  logic [DATA_W-1:0] lane_in,
  output logic [1:0]        mode,
  output logic [3:0]        mode_en,
  output logic [DATA_W-1:0] lane_out,
  output logic              led,
  output logic              wdt_flag
);
  localparam int NMODES = 4;

  logic  ka_edge;
  logic  wdt_expired;
  logic  trip;
  mode_t cur, nxt;
  logic [DATA_W-1:0] lane_q [NMODES];

  mode_wdog #(.TIMEOUT(WDT_CYCLES)) u_wdog (
    .clk(clk), .rst(rst), .ka_in(keepalive), .mask(wdt_mask),
    .ka_edge(ka_edge), .expired(wdt_expired), .flag(wdt_flag)
  );

  assign trip = wdt_flag | alarm;

  mode_fsm u_fsm (
    .clk(clk), .rst(rst), .req(mode_t'(req_mode)), .trip(trip),
    .cur(cur), .nxt(nxt)
  );

  mode_led #(.RUN_HALF(RUN_HALF), .SAFE_HALF(SAFE_HALF)) u_led (
    .clk(clk), .rst(rst), .cur(cur), .nxt(nxt), .led(led)
  );

  for (genvar k = 0; k < NMODES; k++) begin : g_lane
    mode_lane #(.DATA_W(DATA_W), .IDX(k)) u_lane (
      .clk(clk), .rst(rst), .d(lane_in), .q(lane_q[k])
    );
  end

  assign mode     = cur;
  assign mode_en  = mode_onehot(cur);
  assign lane_out = lane_q[cur];
endmodule

// File: rtl/mode_supervisor_chk.sv
module mode_supervisor_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] req_mode,
  input logic       alarm,
  input logic       wdt_mask,
  input logic [1:0] mode,
  input logic [3:0] mode_en,
  input logic       led,
  input logic       wdt_flag,
  input logic       ka_edge,
  input logic       wdt_expired
);
  // R3
  alarm_forces_safe_chk: assert property (@(posedge clk) disable iff (rst)
    alarm |=> mode == 2'd3);

  // R4
  flag_forces_safe_chk: assert property (@(posedge clk) disable iff (rst)
    wdt_flag |=> mode == 2'd3);

  // R6
  safe_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd3 && req_mode != 2'd0) |=> mode == 2'd3);

  // R2
  follow_req_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'd3 && !alarm && !wdt_flag) |=> mode == $past(req_mode));

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (wdt_expired && !ka_edge) |=> wdt_expired);

  // R5
  edge_clears_chk: assert property (@(posedge clk) disable iff (rst)
    ka_edge |=> !wdt_expired);

  // R8
  mask_hides_chk: assert property (@(posedge clk) disable iff (rst)
    wdt_mask |-> !wdt_flag);

  // R10
  enable_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(mode_en) == 1 && mode_en[mode]);

  // R9
  init_led_off_chk: assert property (@(posedge clk) disable iff (rst)
    mode == 2'd0 |-> !led);
endmodule

bind mode_supervisor mode_supervisor_chk u_chk (
  .clk(clk), .rst(rst), .req_mode(req_mode), .alarm(alarm),
  .wdt_mask(wdt_mask), .mode(mode), .mode_en(mode_en), .led(led),
  .wdt_flag(wdt_flag), .ka_edge(ka_edge), .wdt_expired(wdt_expired)
);

// File: tb/tb_mode_supervisor.sv
module tb_mode_supervisor;
  localparam int W    = 8;
  localparam int WDT  = 20;
  localparam int RH   = 6;
  localparam int SH   = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   req_mode = 2'd0;
  logic         keepalive = 1'b0;
  logic         wdt_mask = 1'b0;
  logic         alarm = 1'b0;
  logic [W-1:0] lane_in = '0;
  logic [1:0]   mode;
  logic [3:0]   mode_en;
  logic [W-1:0] lane_out;
  logic         led;
  logic         wdt_flag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit ka_on = 1'b1;
  bit done = 1'b0;

  // reference model state
  int           m_mode = 0;
  int           m_cnt = WDT;
  bit           m_exp = 1'b0;
  bit           m_kaq = 1'b0;
  int           m_n = 0;
  logic [W-1:0] m_lane [4];

  always #5 clk = ~clk;

  mode_supervisor #(.DATA_W(W), .WDT_CYCLES(WDT), .RUN_HALF(RH), .SAFE_HALF(SH)) dut (
    .clk(clk), .rst(rst), .req_mode(req_mode), .keepalive(keepalive),
    .wdt_mask(wdt_mask), .alarm(alarm), .lane_in(lane_in), .mode(mode),
    .mode_en(mode_en), .lane_out(lane_out), .led(led), .wdt_flag(wdt_flag)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic bit exp_led();
    case (m_mode)
      0: return 1'b0;
      1: return 1'b1;
      2: return ((m_n / RH) % 2) == 0;
      default: return ((m_n / SH) % 2) == 0;
    endcase
  endfunction

  // model advances on each edge, outputs compared shortly after
  always @(posedge clk) begin
    bit vis, trip, edge_seen;
    int nm;
    cyc++;
    if (rst) begin
      m_mode = 0; m_cnt = WDT; m_exp = 0; m_kaq = keepalive; m_n = 0;
      for (int k = 0; k < 4; k++) m_lane[k] = '0;
    end else begin
      vis = m_exp && !wdt_mask;
      trip = vis || alarm;
      if (trip) nm = 3;
      else if (m_mode == 3) nm = (req_mode == 2'd0) ? 0 : 3;
      else nm = req_mode;
      edge_seen = (keepalive != m_kaq);
      m_kaq = keepalive;
      if (edge_seen) begin m_cnt = WDT; m_exp = 0; end
      else if (m_cnt == 0) m_exp = 1;
      else m_cnt--;
      if (nm != m_mode) m_n = 0; else m_n++;
      m_mode = nm;
      for (int k = 0; k < 4; k++) m_lane[k] = lane_in + W'(k);
    end
    #2;
    if (!rst) begin
      check("R2/R3/R4/R6/R7 mode", mode, m_mode);
      check("R10 enable", mode_en, 1 << m_mode);
      check("R10 lane_out", lane_out, m_lane[m_mode]);
      check("R9 led", led, exp_led());
      check("R5/R8 wdt_flag", wdt_flag, m_exp && !wdt_mask);
    end
  end

  always @(negedge clk) begin
    lane_in = W'($urandom);
    if (ka_on && (cyc % 5 == 0)) keepalive = ~keepalive;
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog_timer
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog timer expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    // R1: reset state
    check("R1 mode", mode, 0);
    check("R1 enable", mode_en, 1);
    check("R1 led", led, 0);
    check("R1 wdt_flag", wdt_flag, 0);
    rst = 1'b0;
    // R2: follow requests
    req_mode = 2'd1; wait_cyc(4);
    check("R2 stop", mode, 1);
    check("R9 stop led on", led, 1);
    req_mode = 2'd2; wait_cyc(30);
    check("R2 run", mode, 2);
    req_mode = 2'd0; wait_cyc(3);
    req_mode = 2'd2; wait_cyc(5);
    // R3: alarm pulse
    alarm = 1'b1; wait_cyc(1);
    check("R3 alarm to safe", mode, 3);
    req_mode = 2'd0; wait_cyc(3);
    check("R6 init refused under alarm", mode, 3);
    alarm = 1'b0; req_mode = 2'd2; wait_cyc(10);
    check("R6 run refused in safe", mode, 3);
    req_mode = 2'd1; wait_cyc(3);
    check("R6 stop refused in safe", mode, 3);
    req_mode = 2'd0; wait_cyc(1);
    check("R7 leave safe", mode, 0);
    req_mode = 2'd2; wait_cyc(4);
    // R4: stop heartbeat
    ka_on = 1'b0; wait_cyc(WDT + 4);
    check("R4 flag raised", wdt_flag, 1);
    check("R4 mode safe", mode, 3);
    req_mode = 2'd0; wait_cyc(3);
    check("R6 init refused under flag", mode, 3);
    req_mode = 2'd2;
    ka_on = 1'b1; wait_cyc(8);
    check("R5 flag cleared by heartbeat", wdt_flag, 0);
    check("R6 resumed heartbeat keeps safe", mode, 3);
    req_mode = 2'd0; wait_cyc(2);
    check("R7 recover after heartbeat", mode, 0);
    // R8: masked watchdog
    req_mode = 2'd2; wait_cyc(3);
    wdt_mask = 1'b1; ka_on = 1'b0; wait_cyc(WDT + 10);
    check("R8 flag hidden", wdt_flag, 0);
    check("R8 mode stays run", mode, 2);
    wdt_mask = 1'b0; wait_cyc(1);
    check("R8 flag visible after unmask", wdt_flag, 1);
    wait_cyc(1);
    check("R4 safe after unmask", mode, 3);
    wait_cyc(6);
    ka_on = 1'b1; wait_cyc(8);
    req_mode = 2'd0; wait_cyc(2);
    check("R7 final recovery", mode, 0);
    req_mode = 2'd3; wait_cyc(2);
    check("R2 request safe code", mode, 3);
    req_mode = 2'd1; wait_cyc(2);
    check("R6 locked after request", mode, 3);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule